// File: doc/BRIEF.md
# Transmit Highway Time-Slot Multiplexer

This block sits on the transmit side of an E1 framer's system-highway interface. It turns two serial inputs into one transmit bitstream. The inputs are a payload data line and a signaling line. A free-running clock-slot counter and a time-slot counter track the position inside a 32-slot, 256-bit frame. A synchronization pulse presets both counters from programmable offsets. The system clock may run at one, two, four or eight times the bit rate, and one bit is taken per bit period.

A 32-entry marker table holds one bit per time slot. While multiplexing is enabled, that bit decides whether the slot is filled from the signaling line or from the data line. Software loads the table as four bytes into a shadow copy. The shadow copy moves into the working table only when the counters enter slot 0, clock position 0. This means a slot is never split between the two sources.

Each bit that is taken appears one clock later on registered outputs. The outputs carry a strobe, the slot number and the marker that was applied.

Top module: `txh_slot_mux`

## Requirements
- R1: `rate_i` values 0, 1, 2 and 3 give 1, 2, 4 and 8 system clocks per bit. A bit is taken in every cycle where the clock-slot counter is a multiple of that divisor.
- R2: When `sync_i` is high at a rising edge, the time-slot counter loads `ts_ofs_i`. At the same edge, the clock-slot counter loads `cs_ofs_i` modulo the slot length, which is 8 times the divisor.
- R3: When the clock-slot counter reaches the slot length minus one, it returns to 0 and the time slot advances by one. After slot 31 the time slot wraps to slot 0. The bit position within a slot is the clock-slot count divided by the divisor, taken MSB first.
- R4: When `mux_en_i` is 1 and the working marker of the current slot is 1, the bit is taken from `sig_i`. When `mux_en_i` is 1 and that marker is 0, the bit is taken from `data_i`. `mark_o` reports the marker that was applied.
- R5: When `mux_en_i` is 0, every bit is taken from `data_i` and `mark_o` is 0.
- R6: A write with `mark_addr_i` = k sets the shadow markers of slots 8k to 8k+7 from `mark_data_i` bits 0 to 7, where bit j maps to slot 8k+j. The shadow copy becomes the working table only at an edge where the counters move to slot 0, clock position 0. That edge can come from a wrap or from a sync with zero offsets.
- R7: `bit_vld_o` goes high for one cycle, in the cycle after each bit is taken. In that cycle `bit_o` carries the input value from the sampling cycle and `slot_o` carries the slot that was current in the sampling cycle. All three outputs hold their values between strobes.
- R8: Synchronous reset clears both counters, the shadow table, the working table and every output. After reset the frame starts at slot 0, clock position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Synchronization pulse, loads the offsets |
| rate_i | input | 2 | Clocks per bit: 0=1, 1=2, 2=4, 3=8 |
| cs_ofs_i | input | 10 | Clock-slot offset |
| ts_ofs_i | input | 5 | Time-slot offset |
| mux_en_i | input | 1 | Enables per-slot source selection |
| mark_wr_i | input | 1 | Marker byte write strobe |
| mark_addr_i | input | 2 | Marker byte index |
| mark_data_i | input | 8 | Marker byte, bit j for slot 8k+j |
| data_i | input | 1 | Serial payload input |
| sig_i | input | 1 | Serial signaling input |
| bit_o | output | 1 | Merged transmit bit |
| bit_vld_o | output | 1 | Strobe for a new merged bit |
| slot_o | output | 5 | Time slot of the merged bit |
| mark_o | output | 1 | Marker applied to the merged bit |

## Verification
A slot counter that is off by one, or that wraps at the wrong point, shows up on `slot_o` at the next strobe after the fault. A fault in the clock-slot counter or the rate decode changes the spacing of `bit_vld_o` within a single bit period. A working table that loads too early or too late makes `mark_o` and the bit source differ from the expected values in the first slot whose marker changed. With rate 0 that slot can be up to a frame, 256 cycles, away. Every merged bit is compared against a model driven from the same stimulus, so each of these faults is caught at its first visible strobe.

// File: rtl/txh_pkg.sv
package txh_pkg;

  typedef enum logic [1:0] {
    RATE_X1 = 2'd0,
    RATE_X2 = 2'd1,
    RATE_X4 = 2'd2,
    RATE_X8 = 2'd3
  } rate_e;

  // source choice for one merged bit
  function automatic logic pick_src(input logic en, input logic mark,
                                    input logic dat, input logic sig);
    return (en && mark) ? sig : dat;
  endfunction

endpackage

// File: rtl/txh_slot_counter.sv
module txh_slot_counter #(
  parameter int NSLOT       = 32,
  parameter int SLOT_BITS   = 8,
  parameter int MAX_DIV_LOG = 3,
  parameter int CS_OFS_W    = 10,
  localparam int TS_W   = $clog2(NSLOT),
  localparam int BIT_W  = $clog2(SLOT_BITS),
  localparam int CNT_W  = BIT_W + MAX_DIV_LOG,
  localparam int RATE_W = $clog2(MAX_DIV_LOG + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sync_i,
  input  logic [RATE_W-1:0]   rate_i,
  input  logic [CS_OFS_W-1:0] cs_ofs_i,
  input  logic [TS_W-1:0]     ts_ofs_i,
  output logic [TS_W-1:0]     ts_o,
  output logic                sample_o,
  output logic                frame_start_o
);

  localparam logic [CNT_W-1:0] ONES = '1;

  logic [CNT_W-1:0] cs_q, cs_d, len_m1, div_mask;
  logic [TS_W-1:0]  ts_q, ts_d;

  // last clock position of a slot and clock-per-bit mask for this rate
  assign len_m1   = ONES >> (RATE_W'(MAX_DIV_LOG) - rate_i);
  assign div_mask = len_m1 >> BIT_W;

  always_comb begin
    cs_d = cs_q;
    ts_d = ts_q;
    if (sync_i) begin
      cs_d = CNT_W'(cs_ofs_i & CS_OFS_W'(len_m1));
      ts_d = ts_ofs_i;
    end else if (cs_q >= len_m1) begin
      cs_d = '0;
      ts_d = (ts_q == TS_W'(NSLOT - 1)) ? '0 : ts_q + 1'b1;
    end else begin
      cs_d = cs_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q <= '0;
      ts_q <= '0;
    end else begin
      cs_q <= cs_d;
      ts_q <= ts_d;
    end
  end

  assign ts_o          = ts_q;
  assign sample_o      = (cs_q & div_mask) == '0;
  assign frame_start_o = (cs_d == '0) && (ts_d == '0);

  // R2: sync presets the time slot from the offset
  p_sync_load_r2: assert property (@(posedge clk) disable iff (rst)
    sync_i |=> (ts_q == $past(ts_ofs_i)));

  // R2: loaded clock position stays inside the slot
  p_cs_bound_r2: assert property (@(posedge clk) disable iff (rst)
    sync_i |=> (cs_q <= $past(len_m1)));

  // R3: slot holds until its last clock position
  p_slot_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!sync_i && cs_q < len_m1) |=> $stable(ts_q));

  // R3: slot steps by one (wrapping) at the end of a slot
  p_slot_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!sync_i && cs_q == len_m1) |=> (ts_q == TS_W'($past(ts_q) + 1'b1)));

endmodule

// File: rtl/txh_marker_table.sv
module txh_marker_table #(
  parameter int NSLOT = 32,
  localparam int NBYTE = NSLOT / 8,
  localparam int AW    = (NBYTE > 1) ? $clog2(NBYTE) : 1,
  localparam int TS_W  = $clog2(NSLOT)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [7:0]      data_i,
  input  logic            load_i,
  input  logic [TS_W-1:0] slot_i,
  output logic            mark_o
);

  logic [7:0]       shadow_q [NBYTE];
  logic [NSLOT-1:0] active_q;

  // shadow bytes take software writes at any time
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NBYTE; k++) shadow_q[k] <= '0;
    end else if (wr_i) begin
      for (int k = 0; k < NBYTE; k++)
        if (addr_i == AW'(k)) shadow_q[k] <= data_i;
    end
  end

  // working table only changes on a frame boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= '0;
    end else if (load_i) begin
      for (int k = 0; k < NBYTE; k++) active_q[k*8 +: 8] <= shadow_q[k];
    end
  end

  assign mark_o = active_q[slot_i];

  // R6: no change of the working table away from a frame boundary
  p_table_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(active_q));

endmodule

// File: rtl/txh_out_stage.sv
module txh_out_stage
  import txh_pkg::*;
#(
  parameter int TS_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sample_i,
  input  logic [TS_W-1:0] slot_i,
  input  logic            en_i,
  input  logic            mark_i,
  input  logic            data_i,
  input  logic            sig_i,
  output logic            bit_o,
  output logic            vld_o,
  output logic [TS_W-1:0] slot_o,
  output logic            mark_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_o  <= 1'b0;
      vld_o  <= 1'b0;
      slot_o <= '0;
      mark_o <= 1'b0;
    end else begin
      vld_o <= sample_i;
      if (sample_i) begin
        bit_o  <= pick_src(en_i, mark_i, data_i, sig_i);
        slot_o <= slot_i;
        mark_o <= en_i && mark_i;
      end
    end
  end

  // R7: outputs hold between strobes
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !sample_i |=> ($stable(bit_o) && $stable(slot_o) && $stable(mark_o)));

endmodule

// File: rtl/txh_slot_mux.sv
module txh_slot_mux
  import txh_pkg::*;
#(
  parameter int NSLOT       = 32,
  parameter int SLOT_BITS   = 8,
  parameter int MAX_DIV_LOG = 3,
  parameter int CS_OFS_W    = 10,
  localparam int TS_W   = $clog2(NSLOT),
  localparam int NBYTE  = NSLOT / 8,
  localparam int AW     = (NBYTE > 1) ? $clog2(NBYTE) : 1,
  localparam int RATE_W = $clog2(MAX_DIV_LOG + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sync_i,
  input  logic [RATE_W-1:0]   rate_i,
  input  logic [CS_OFS_W-1:0] cs_ofs_i,
  input  logic [TS_W-1:0]     ts_ofs_i,
  input  logic                mux_en_i,
  input  logic                mark_wr_i,
  input  logic [AW-1:0]       mark_addr_i,
  input  logic [7:0]          mark_data_i,
  input  logic                data_i,
  input  logic                sig_i,
  output logic                bit_o,
  output logic                bit_vld_o,
  output logic [TS_W-1:0]     slot_o,
  output logic                mark_o
);

  logic [TS_W-1:0] cur_slot;
  logic            sample, frame_start, slot_mark;

  txh_slot_counter #(
    .NSLOT(NSLOT), .SLOT_BITS(SLOT_BITS),
    .MAX_DIV_LOG(MAX_DIV_LOG), .CS_OFS_W(CS_OFS_W)
  ) u_cnt (
    .clk(clk), .rst(rst), .sync_i(sync_i), .rate_i(rate_i),
    .cs_ofs_i(cs_ofs_i), .ts_ofs_i(ts_ofs_i), .ts_o(cur_slot),
    .sample_o(sample), .frame_start_o(frame_start)
  );

  txh_marker_table #(.NSLOT(NSLOT)) u_tbl (
    .clk(clk), .rst(rst), .wr_i(mark_wr_i), .addr_i(mark_addr_i),
    .data_i(mark_data_i), .load_i(frame_start), .slot_i(cur_slot),
    .mark_o(slot_mark)
  );

  txh_out_stage #(.TS_W(TS_W)) u_out (
    .clk(clk), .rst(rst), .sample_i(sample), .slot_i(cur_slot),
    .en_i(mux_en_i), .mark_i(slot_mark), .data_i(data_i), .sig_i(sig_i),
    .bit_o(bit_o), .vld_o(bit_vld_o), .slot_o(slot_o), .mark_o(mark_o)
  );

  // R1: at more than one clock per bit, strobes never come back to back
  p_vld_gap_r1: assert property (@(posedge clk) disable iff (rst)
    (bit_vld_o && rate_i != '0 && rate_i == $past(rate_i) && !$past(sync_i))
      |=> !bit_vld_o);

  // R4: a marked bit comes from the signaling line
  p_mark_src_r4: assert property (@(posedge clk) disable iff (rst)
    (bit_vld_o && mark_o) |-> (bit_o == $past(sig_i)));

  // R5: multiplexing off gives no marked bits
  p_mark_off_r5: assert property (@(posedge clk) disable iff (rst)
    !mux_en_i |=> (!bit_vld_o || !mark_o));

endmodule

// File: tb/txh_slot_mux_test.sv
module txh_slot_mux_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sync_i = 1'b0;
  logic [1:0] rate_i = 2'd0;
  logic [9:0] cs_ofs_i = '0;
  logic [4:0] ts_ofs_i = '0;
  logic       mux_en_i = 1'b0;
  logic       mark_wr_i = 1'b0;
  logic [1:0] mark_addr_i = '0;
  logic [7:0] mark_data_i = '0;
  logic       data_i = 1'b0;
  logic       sig_i = 1'b0;
  logic       bit_o, bit_vld_o, mark_o;
  logic [4:0] slot_o;

  txh_slot_mux uut (
    .clk(clk), .rst(rst), .sync_i(sync_i), .rate_i(rate_i),
    .cs_ofs_i(cs_ofs_i), .ts_ofs_i(ts_ofs_i), .mux_en_i(mux_en_i),
    .mark_wr_i(mark_wr_i), .mark_addr_i(mark_addr_i),
    .mark_data_i(mark_data_i), .data_i(data_i), .sig_i(sig_i),
    .bit_o(bit_o), .bit_vld_o(bit_vld_o), .slot_o(slot_o), .mark_o(mark_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    bit    vld;
    bit    b;
    int    slot;
    bit    mark;
    string req;
  } exp_t;

  exp_t  sb_q[$];
  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  string cur_req = "R8";

  // bench model of the requirements
  int       m_cs = 0, m_ts = 0, m_rate = 0;
  bit       m_en = 0;
  bit [7:0] m_sh [4];
  bit [31:0] m_act = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: one clock of stimulus, pushes the expected result
  task automatic step(input bit sy, input int cso, input int tso,
                      input bit wr, input int wa, input bit [7:0] wd);
    exp_t e;
    bit d, s, sel;
    int div, len, ncs, nts;
    @(negedge clk);
    d = 1'($urandom);
    s = 1'($urandom);
    rst = 1'b0;
    sync_i = sy; cs_ofs_i = 10'(cso); ts_ofs_i = 5'(tso);
    rate_i = 2'(m_rate); mux_en_i = m_en;
    mark_wr_i = wr; mark_addr_i = 2'(wa); mark_data_i = wd;
    data_i = d; sig_i = s;
    div = 1 << m_rate;
    len = 8 * div;
    sel = m_en && m_act[m_ts];
    e.vld = (m_cs % div) == 0;
    e.b = sel ? s : d;
    e.slot = m_ts;
    e.mark = sel;
    e.req = cur_req;
    sb_q.push_back(e);
    if (sy) begin
      ncs = cso % len; nts = tso;
    end else if (m_cs >= len - 1) begin
      ncs = 0; nts = (m_ts + 1) % 32;
    end else begin
      ncs = m_cs + 1; nts = m_ts;
    end
    if (ncs == 0 && nts == 0) m_act = {m_sh[3], m_sh[2], m_sh[1], m_sh[0]};
    if (wr) m_sh[wa] = wd;
    m_cs = ncs;
    m_ts = nts;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 8'h00);
  endtask

  // monitor: compares each cycle's outputs against the queue
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (!done && sb_q.size() > 0) begin
      e = sb_q.pop_front();
      chk(bit_vld_o == e.vld, {e.req, " R1 R7"}, "bit_vld_o", int'(bit_vld_o), int'(e.vld));
      if (e.vld) begin
        chk(int'(slot_o) == e.slot, {e.req, " R3"}, "slot_o", int'(slot_o), e.slot);
        chk(bit_o == e.b, {e.req, e.mark ? " R4" : " R5"}, "bit_o", int'(bit_o), int'(e.b));
        chk(mark_o == e.mark, {e.req, " R4 R5"}, "mark_o", int'(mark_o), int'(e.mark));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) m_sh[k] = '0;
    repeat (3) @(posedge clk);
    #2;
    // R8: reset state at the ports
    chk(bit_vld_o == 1'b0, "R8", "bit_vld_o", int'(bit_vld_o), 0);
    chk(bit_o == 1'b0, "R8", "bit_o", int'(bit_o), 0);
    chk(slot_o == 5'd0, "R8", "slot_o", int'(slot_o), 0);
    chk(mark_o == 1'b0, "R8", "mark_o", int'(mark_o), 0);

    cur_req = "R8";
    run(20);

    // R6: table written mid-frame, applies only after the wrap
    cur_req = "R6";
    m_en = 1;
    step(0, 0, 0, 1, 0, 8'hA5);
    step(0, 0, 0, 1, 1, 8'h3C);
    step(0, 0, 0, 1, 2, 8'hF0);
    step(0, 0, 0, 1, 3, 8'h81);
    run(600);

    // R5: multiplexing off
    cur_req = "R5";
    m_en = 0;
    run(300);

    // R2: sync with offsets at two clocks per bit
    cur_req = "R2";
    m_en = 1;
    m_rate = 1;
    step(1, 5, 30, 0, 0, 8'h00);
    run(200);
    // R6: new byte then sync to zero loads it at once
    cur_req = "R6";
    step(0, 0, 0, 1, 0, 8'h0F);
    run(5);
    step(1, 0, 0, 0, 0, 8'h00);
    run(150);

    // R1: four and eight clocks per bit, large offsets reduced
    cur_req = "R1";
    m_rate = 2;
    step(1, 1000, 3, 0, 0, 8'h00);
    run(1200);
    m_rate = 3;
    step(1, 1023, 31, 1, 2, 8'h5A);
    run(3000);

    // R3: wrap from slot 31 at one clock per bit
    cur_req = "R3";
    m_rate = 0;
    step(1, 7, 31, 0, 0, 8'h00);
    run(600);

    cur_req = "R4";
    step(0, 0, 0, 1, 1, 8'hFF);
    run(520);

    @(negedge clk);
    @(posedge clk);
    #3;
    chk(sb_q.size() == 0, "R7", "queue_left", sb_q.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule